// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that lets a host processor read and write a small bank of byte-wide control registers. The host pulls the select line low, clocks in a command byte, then a subaddress byte, and then any number of data bytes. A write command stores each data byte into the register that the subaddress pointer names. A read command returns register contents on the serial output. After each data byte the pointer steps forward by one, so a single transaction can sweep a run of consecutive registers.

The block runs from a fast system clock. The serial clock, select and data inputs are oversampled through synchronizers, and the block acts on edges found in the synchronized serial clock. Each register carries a fixed access attribute set by parameter masks. A read-only register takes its value from a hardware input and ignores host writes. A write-only register accepts writes but reads back as zero. The stored register values are presented in parallel to the logic the registers control. The serial output comes with a separate drive-enable for the pad.

Top module: `spi_regport`

## Requirements
- R1: Bytes are shifted most significant bit first. Input bits are taken on rising serial clock edges, counted from the first rising edge after select goes low, with the serial clock idling low.
- R2: A command byte of 0xD4 starts a write. The next byte loads the subaddress pointer, and each byte after that is stored into the register the pointer names.
- R3: A command byte of 0xD5 starts a read. On each falling serial clock edge of a data byte, the block launches the next bit of the addressed register onto the serial output, starting with the falling edge that ends the subaddress byte.
- R4: After each completed data byte the 8-bit subaddress pointer increments by one, wrapping from 0xFF to 0x00, in both reads and writes.
- R5: A register marked read-only ignores host writes. It reads back, and appears on the parallel output, as its hardware status input sampled one system clock earlier.
- R6: A register marked write-only stores host writes and drives them on the parallel output, but reads back as 0x00.
- R7: A subaddress at or above the number of registers is not backed by storage: writes to it change nothing and reads of it return 0x00.
- R8: Raising select discards any partial byte, and the next transaction begins again with a command byte.
- R9: A command byte other than 0xD4 or 0xD5 causes every later byte of that transaction to be ignored.
- R10: The serial output enable is low while select is high, during write and ignored transactions, and during the command byte. It is high only during the rest of a read transaction.
- R11: After a synchronous reset, every register that is not read-only holds 0x00 and the serial output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must be several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, valid when the enable is high |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| hw_status | input | NREG*8 | Values for the read-only registers, register i in bits [8i+7:8i] |
| reg_q | output | NREG*8 | Parallel register contents, register i in bits [8i+7:8i] |

## Verification
The registers are first filled with a single burst from subaddress zero and read back in a second burst. This shows the auto-increment, the read-only and write-only attributes, and the bit order over all sixteen registers in one pass. Each register is then written and read back in its own transaction with distinct values. A pointer fault that only appears in bursts is told apart this way from a fault in loading the subaddress. Further transactions start near 0xFF to show the wrap and the unbacked subaddresses, cut a data byte in half by raising select, and send an unknown command. In each case a following normal read shows that nothing was disturbed. The output enable is sampled on every data bit, which shows whether it is driven only during reads.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam logic [7:0] CMD_WRITE = 8'hD4;
  localparam logic [7:0] CMD_READ  = 8'hD5;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_SUB  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_prev
);

  localparam int CHAIN = STAGES + 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [CHAIN-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {CHAIN{RST_VAL[b]}};
      else     chain <= {chain[CHAIN-2:0], din[b]};
    end
    assign dout[b]      = chain[STAGES-1];
    assign dout_prev[b] = chain[STAGES];
  end

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi_s,
  input  logic [7:0]       rd_byte,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             miso,
  output logic             miso_oe
);

  localparam int BIT_W = 3;

  logic [BIT_W-1:0] bitcnt;
  logic [7:0]       rx_sr;
  logic [7:0]       rx_next;
  logic [7:0]       tx_sr;
  logic             rd_mode;
  logic             byte_done;
  phase_t           phase;

  assign rx_next   = {rx_sr[6:0], mosi_s};
  assign byte_done = sel && sclk_rise && (bitcnt == BIT_W'(7));
  assign wr_en     = byte_done && (phase == PH_DATA) && !rd_mode;
  assign wr_data   = rx_next;
  assign miso      = tx_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (byte_done) begin
      if (phase == PH_SUB)       ptr <= PTR_W'(rx_next);
      else if (phase == PH_DATA) ptr <= ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rd_mode <= 1'b0;
      phase   <= PH_CMD;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= rd_mode;
      if (sclk_rise) begin
        rx_sr  <= rx_next;
        bitcnt <= bitcnt + BIT_W'(1);
        if (bitcnt == BIT_W'(7)) begin
          unique case (phase)
            PH_CMD: begin
              if (rx_next == CMD_READ) begin
                rd_mode <= 1'b1;
                phase   <= PH_SUB;
              end else if (rx_next == CMD_WRITE) begin
                rd_mode <= 1'b0;
                phase   <= PH_SUB;
              end else begin
                phase   <= PH_SKIP;
              end
            end
            PH_SUB:  phase <= PH_DATA;
            PH_DATA: phase <= PH_DATA;
            PH_SKIP: phase <= PH_SKIP;
          endcase
        end
      end
      if (sclk_fall && rd_mode && phase == PH_DATA) begin
        if (bitcnt == '0) tx_sr <= rd_byte;
        else              tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  p_bitcnt_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (bitcnt == '0));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_DATA) |=> (ptr == $past(ptr) + PTR_W'(1)));

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && !sclk_fall) |=> $stable(tx_sr));

  p_oe_needs_sel_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> !miso_oe);

endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile #(
  parameter int              NREG    = 16,
  parameter int              PTR_W   = 8,
  parameter logic [NREG-1:0] RO_MASK = '0,
  parameter logic [NREG-1:0] WO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  addr,
  input  logic [7:0]        wr_data,
  input  logic [NREG*8-1:0] hw_ro,
  output logic [7:0]        rd_byte,
  output logic [NREG*8-1:0] regs
);

  logic [NREG-1:0][7:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (RO_MASK[i])                           mem[i] <= hw_ro[i*8 +: 8];
        else if (wr_en && addr == PTR_W'(i))      mem[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (addr == PTR_W'(i) && !WO_MASK[i]) rd_byte = mem[i];
    end
  end

  assign regs = mem;

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    if (RO_MASK[g]) begin : g_ro
      p_ro_tracks_hw_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mem[g] == $past(hw_ro[g*8 +: 8])));
    end else begin : g_rw
      p_hold_unless_written_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en && addr == PTR_W'(g))) |-> $stable(mem[g]));
    end
  end

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int              NREG    = 16,
  parameter logic [NREG-1:0] RO_MASK = 16'h0300,
  parameter logic [NREG-1:0] WO_MASK = 16'h0030,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [NREG*8-1:0] hw_status,
  output logic [NREG*8-1:0] reg_q
);

  localparam int PTR_W = 8;

  logic [2:0]       pins_s;
  logic [2:0]       pins_p;
  logic             sel;
  logic             sclk_rise;
  logic             sclk_fall;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       rd_byte;

  spi_regport_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .din       ({spi_mosi, spi_sclk, spi_cs_n}),
    .dout      (pins_s),
    .dout_prev (pins_p)
  );

  assign sel       = !pins_s[0];
  assign sclk_rise =  pins_s[1] && !pins_p[1];
  assign sclk_fall = !pins_s[1] &&  pins_p[1];

  spi_regport_ctrl #(
    .PTR_W (PTR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (pins_s[2]),
    .rd_byte   (rd_byte),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

  spi_regport_regfile #(
    .NREG    (NREG),
    .PTR_W   (PTR_W),
    .RO_MASK (RO_MASK),
    .WO_MASK (WO_MASK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (ptr),
    .wr_data (wr_data),
    .hw_ro   (hw_status),
    .rd_byte (rd_byte),
    .regs    (reg_q)
  );

endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;

  localparam int NREG = 16;
  localparam logic [NREG-1:0] RO_M = 16'h0300;
  localparam logic [NREG-1:0] WO_M = 16'h0030;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic spi_miso_oe;
  logic [NREG*8-1:0] hw_status;
  logic [NREG*8-1:0] reg_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] model  [NREG];
  logic [7:0] hw_val [NREG];
  logic [7:0] wbuf   [32];
  logic [7:0] rbuf   [32];
  logic oe_hi, oe_lo;

  always #5 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .hw_status(hw_status), .reg_q(reg_q)
  );

  always_comb for (int i = 0; i < NREG; i++) hw_status[i*8 +: 8] = hw_val[i];

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a >= NREG) return 8'h00;
    if (RO_M[a]) return hw_val[a];
    if (WO_M[a]) return 8'h00;
    return model[a];
  endfunction

  function automatic logic [7:0] exp_q(input int a);
    return RO_M[a] ? hw_val[a] : model[a];
  endfunction

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int k = 7; k > 7 - nb; k--) begin
      spi_mosi = tx[k];
      half();
      rx[k] = spi_miso;
      if (spi_miso_oe) oe_hi = 1'b1; else oe_lo = 1'b1;
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
    end
  endtask

  task automatic begin_xfer();
    @(negedge clk);
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic end_xfer();
    half();
    spi_cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic do_write(input logic [7:0] sub, input int n);
    logic [7:0] d;
    begin_xfer();
    xbits(8'hD4, 8, d);
    xbits(sub, 8, d);
    oe_hi = 1'b0; oe_lo = 1'b0;
    for (int j = 0; j < n; j++) begin
      xbits(wbuf[j], 8, d);
      if (int'(8'(sub + j)) < NREG && !RO_M[8'(sub + j)]) model[8'(sub + j)] = wbuf[j];
    end
    end_xfer();
  endtask

  task automatic do_read(input logic [7:0] sub, input int n);
    logic [7:0] d;
    begin_xfer();
    xbits(8'hD5, 8, d);
    xbits(sub, 8, d);
    oe_hi = 1'b0; oe_lo = 1'b0;
    for (int j = 0; j < n; j++) xbits(8'h00, 8, rbuf[j]);
    end_xfer();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) begin
      hw_val[i] = 8'hA0 + 8'(i);
      model[i]  = 8'h00;
    end
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 oe", {7'd0, spi_miso_oe}, 8'h00);
    for (int i = 0; i < NREG; i++) check("R11/R5 reg_q", reg_q[i*8 +: 8], exp_q(i));

    // R2/R1 burst write over the whole file, R5 ignored writes
    for (int j = 0; j < NREG; j++) wbuf[j] = 8'(j * 29 + 7);
    do_write(8'h00, NREG);
    check("R10 oe low in write", {7'd0, oe_hi}, 8'h00);
    for (int i = 0; i < NREG; i++) check("R2/R4/R5/R6 reg_q", reg_q[i*8 +: 8], exp_q(i));

    // R3/R4 burst read, R6 write-only reads zero
    do_read(8'h00, NREG);
    check("R10 oe high in read", {7'd0, oe_lo}, 8'h00);
    for (int i = 0; i < NREG; i++) check("R3/R4/R5/R6 readback", rbuf[i], exp_rd(i));
    check("R10 oe low after select", {7'd0, spi_miso_oe}, 8'h00);

    // single-register transactions at every subaddress
    for (int i = 0; i < NREG; i++) begin
      wbuf[0] = ~8'(i * 29 + 7) ^ 8'(i << 4);
      do_write(8'(i), 1);
    end
    for (int i = 0; i < NREG; i++) begin
      do_read(8'(i), 1);
      check("R2/R3 single readback", rbuf[0], exp_rd(i));
      check("R1 reg_q single", reg_q[i*8 +: 8], exp_q(i));
    end

    // R5 hardware value change reaches readback
    hw_val[8] = 8'h5C;
    repeat (4) @(negedge clk);
    do_read(8'h08, 2);
    check("R5 ro after hw change", rbuf[0], 8'h5C);
    check("R5 ro neighbour", rbuf[1], exp_rd(9));

    // R8 abort in mid byte
    begin_xfer();
    xbits(8'hD4, 8, d);
    xbits(8'h02, 8, d);
    xbits(8'hFF, 4, d);
    end_xfer();
    check("R8 aborted byte not stored", reg_q[2*8 +: 8], model[2]);
    do_read(8'h02, 1);
    check("R8 next transaction normal", rbuf[0], model[2]);

    // R9 unknown command
    oe_hi = 1'b0;
    begin_xfer();
    xbits(8'h5A, 8, d);
    xbits(8'h03, 8, d);
    xbits(8'hEE, 8, d);
    end_xfer();
    check("R9 unknown cmd no write", reg_q[3*8 +: 8], model[3]);
    check("R9/R10 unknown cmd oe", {7'd0, oe_hi}, 8'h00);

    // R4/R7 wrap and unbacked subaddresses
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'hFE, 3);
    check("R4 wrap write reg0", reg_q[7:0], 8'h33);
    check("R7 reg1 untouched", reg_q[15:8], model[1]);
    do_read(8'hFF, 2);
    check("R7 read unbacked", rbuf[0], 8'h00);
    check("R4 wrap read reg0", rbuf[1], 8'h33);
    do_read(8'h20, 1);
    check("R7 read 0x20", rbuf[0], 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule